// File: doc/BRIEF.md
# Host-Set Control Pins with Change Interrupt

This block owns two general-purpose digital pins on an audio processing chip that a host configures. A simple register port (write strobe, address, data; read strobe, address, registered read data) reaches three registers: a level register whose low two bits give the driven level of pin 0 and pin 1, a mode register that can release both pins to act as inputs or turn pin 1 into an interrupt request, and a read-only status register that shows the synchronized pin levels.

The level register's reset value is deferred. After reset nothing drives the pins and the level register reads zero. The first host write of any kind starts the block. If that write targets the level register, the written value is loaded. Otherwise the parameter default is loaded. When the interrupt mode is on, pin 1 is always driven. It carries a level-high request that sets on any change of the status contents and stays set until the host reads the status register. The host port has no back-pressure: every strobe is taken in the cycle it is seen, and a read returns its data one cycle later.

Top module: `ctlpin_ctrl`

## Requirements
- R1: After reset and until the first write, `pin_oe` and `pin_out` are both 0, and reads of address 0 (level) and address 1 (mode) return 0.
- R2: If the first write after reset goes to any address other than 0, the level register takes `CTL_DEFAULT` (default 8'h03) at that edge.
- R3: If the first write after reset goes to address 0, the level register takes the written data and not `CTL_DEFAULT`.
- R4: Once started, with mode bit 0 clear and mode bit 1 clear, `pin_oe` is 2'b11 and `pin_out[i]` equals level bit i. Both follow a write from the next cycle.
- R5: With mode bit 0 set (release), every pin that is not serving as the interrupt has `pin_oe` 0 and `pin_out` 0.
- R6: Status (address 2) bits [1:0] show `pin_in[1:0]`. A change at the input appears in status at the third rising edge after it. Bit 1 reads 0 while mode bit 1 is set.
- R7: With mode bit 1 set (interrupt), `pin_oe[1]` is 1 whatever mode bit 0 says, `pin_out[1]` is the pending request, and level bit 1 has no effect on the pin.
- R8: While the interrupt is enabled, any change in the status contents sets the request. The request stays set until a read of address 2 and clears at that read's edge. It is held clear while the interrupt is disabled.
- R9: A status change at the same edge as a status read leaves the request set.
- R10: `rd_data` is updated one edge after `rd_en` and holds otherwise. Address 3 reads 0. Writes to addresses 2 and 3 change no register, though they still count as the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Write address (0 level, 1 mode, 2 status) |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| pin_in | input | 2 | Pad input levels |
| pin_out | output | 2 | Pad output levels |
| pin_oe | output | 2 | Pad output enables |

## Verification
A write reaches `pin_oe` and `pin_out` in the cycle after its edge, because the pins decode registers directly. Read data arrives one edge after the strobe. An input change reaches status and the request three edges later: two synchronizer flops, then the status flop. The bench holds a behavioural model that advances at each rising edge from the inputs applied half a cycle earlier. It compares all three outputs at every falling edge, so each result is checked in exactly the cycle in which it falls due. The same-edge case for R9 is built by issuing the read two cycles after the input change.

// File: rtl/ctlpin_pkg.sv
package ctlpin_pkg;
  localparam int NPIN        = 2;
  localparam int ADDR_LEVEL  = 0;
  localparam int ADDR_MODE   = 1;
  localparam int ADDR_STATUS = 2;
  localparam int MODE_W      = 2;
  localparam int MODE_REL    = 0;  // release pins to inputs
  localparam int MODE_IRQ    = 1;  // pin 1 becomes the request

  typedef struct packed {
    logic irq_en;
    logic release_en;
  } mode_t;
endpackage

// File: rtl/ctlpin_regs.sv
module ctlpin_regs
  import ctlpin_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [DATA_W-1:0] CTL_DEFAULT = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              started,
  output logic [DATA_W-1:0] level_q,
  output mode_t             mode_q
);
  logic hit_level, hit_mode;
  assign hit_level = wr_en && (wr_addr == ADDR_W'(ADDR_LEVEL));
  assign hit_mode  = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      level_q <= '0;
      mode_q  <= '0;
    end else begin
      if (wr_en) started <= 1'b1;
      if (hit_level) level_q <= wr_data;
      else if (wr_en && !started) level_q <= CTL_DEFAULT;
      if (hit_mode) begin
        mode_q.release_en <= wr_data[MODE_REL];
        mode_q.irq_en     <= wr_data[MODE_IRQ];
      end
    end
  end

  // R2
  default_on_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !started && wr_addr != ADDR_W'(ADDR_LEVEL)) |=> (level_q == CTL_DEFAULT));
  // R3
  first_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_level && !started) |=> (level_q == $past(wr_data)));
  // R1
  idle_until_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!started && !wr_en) |=> (level_q == '0 && mode_q == '0));
endmodule

// File: rtl/ctlpin_sync.sv
module ctlpin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/ctlpin_status.sv
module ctlpin_status
  import ctlpin_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] sync_lvl,
  input  logic            irq_en,
  input  logic            rd_clr,
  output logic [NPIN-1:0] status_q,
  output logic            pend_q
);
  logic [NPIN-1:0] status_nxt;
  logic            changed;

  always_comb begin
    status_nxt    = sync_lvl;
    status_nxt[1] = sync_lvl[1] & ~irq_en;
  end
  assign changed = (status_nxt != status_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      status_q <= status_nxt;
      if (!irq_en)      pend_q <= 1'b0;
      else if (changed) pend_q <= 1'b1;
      else if (rd_clr)  pend_q <= 1'b0;
    end
  end

  // R8
  pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && pend_q && !rd_clr) |=> pend_q);
  // R9
  read_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && rd_clr && changed) |=> pend_q);
  // R8
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !pend_q);
endmodule

// File: rtl/ctlpin_drive.sv
module ctlpin_drive
  import ctlpin_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            started,
  input  mode_t           mode,
  input  logic [NPIN-1:0] level,
  input  logic            pend,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);
  logic drive_all;
  assign drive_all = started && !mode.release_en;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i == 1) begin : g_irq
      always_comb begin
        if (mode.irq_en) begin
          pin_oe[i]  = 1'b1;
          pin_out[i] = pend;
        end else begin
          pin_oe[i]  = drive_all;
          pin_out[i] = drive_all & level[i];
        end
      end
    end else begin : g_plain
      assign pin_oe[i]  = drive_all;
      assign pin_out[i] = drive_all & level[i];
    end
  end

  // R1
  quiet_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (pin_oe == '0 && pin_out == '0));
  // R7
  irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode.irq_en |-> (pin_oe[1] && pin_out[1] == pend));
  // R5
  released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode.release_en |-> (!pin_oe[0] && !pin_out[0]));
endmodule

// File: rtl/ctlpin_ctrl.sv
module ctlpin_ctrl
  import ctlpin_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CTL_DEFAULT = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        pin_in,
  output logic [1:0]        pin_out,
  output logic [1:0]        pin_oe
);
  localparam int PAD_MODE = DATA_W - MODE_W;
  localparam int PAD_STAT = DATA_W - NPIN;

  logic              started;
  logic [DATA_W-1:0] level_q;
  mode_t             mode_q;
  logic [NPIN-1:0]   sync_lvl, status_q;
  logic              pend_q, rd_clr;
  logic [DATA_W-1:0] rd_nxt;

  ctlpin_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTL_DEFAULT(CTL_DEFAULT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .started(started), .level_q(level_q), .mode_q(mode_q));

  ctlpin_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl));

  assign rd_clr = rd_en && (rd_addr == ADDR_W'(ADDR_STATUS));

  ctlpin_status u_status (
    .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .irq_en(mode_q.irq_en),
    .rd_clr(rd_clr), .status_q(status_q), .pend_q(pend_q));

  ctlpin_drive u_drive (
    .clk(clk), .rst_n(rst_n), .started(started), .mode(mode_q),
    .level(level_q[NPIN-1:0]), .pend(pend_q), .pin_out(pin_out), .pin_oe(pin_oe));

  always_comb begin
    unique case (rd_addr)
      ADDR_W'(ADDR_LEVEL):  rd_nxt = level_q;
      ADDR_W'(ADDR_MODE):   rd_nxt = {{PAD_MODE{1'b0}}, mode_q};
      ADDR_W'(ADDR_STATUS): rd_nxt = {{PAD_STAT{1'b0}}, status_q};
      default:              rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/ctlpin_ctrl_bench.sv
module ctlpin_ctrl_bench;
  localparam logic [7:0] DEF = 8'h03;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0, pin_in = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [1:0] pin_out, pin_oe;

  ctlpin_ctrl u_ctlpin_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference state
  bit       m_run;
  bit [7:0] m_lvl, m_rd;
  bit       m_rel, m_irq, m_pend;
  bit [1:0] m_s1, m_s2, m_stat;

  always @(posedge clk) begin
    bit [1:0] nstat;
    cycles++;
    if (!rst_n) begin
      m_run = 0; m_lvl = 0; m_rd = 0; m_rel = 0; m_irq = 0; m_pend = 0;
      m_s1 = 0; m_s2 = 0; m_stat = 0;
    end else begin
      nstat = {m_s2[1] & ~m_irq, m_s2[0]};
      if (!m_irq) m_pend = 0;
      else if (nstat != m_stat) m_pend = 1;
      else if (rd_en && rd_addr == 2) m_pend = 0;
      if (rd_en)
        case (rd_addr)
          0: m_rd = m_lvl;
          1: m_rd = {6'd0, m_irq, m_rel};
          2: m_rd = {6'd0, m_stat};
          default: m_rd = 0;
        endcase
      if (wr_en) begin
        if (wr_addr == 0) m_lvl = wr_data;
        else if (!m_run) m_lvl = DEF;
        if (wr_addr == 1) begin m_rel = wr_data[0]; m_irq = wr_data[1]; end
        m_run = 1;
      end
      m_stat = nstat; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit [1:0] eoe, eout;
    if (rst_n) begin
      eoe[0]  = m_run && !m_rel;
      eout[0] = eoe[0] & m_lvl[0];
      eoe[1]  = m_irq ? 1'b1 : eoe[0];
      eout[1] = m_irq ? m_pend : (eoe[0] & m_lvl[1]);
      cmp("pin_oe", {6'd0, pin_oe}, {6'd0, eoe});
      cmp("pin_out", {6'd0, pin_out}, {6'd0, eout});
      cmp("rd_data", rd_data, m_rd);
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d; rd_en = 0;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(logic [1:0] a);
    @(negedge clk); rd_en = 1; rd_addr = a; wr_en = 0;
    @(negedge clk); rd_en = 0;
  endtask
  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0; rd_en = 0;
    step(3); rst_n = 1;
  endtask

  initial begin
    fork
      begin
        do_reset();
        tag = "R1"; pin_in = 2'b11; step(5); rd(0); rd(1); pin_in = 2'b01; step(4);
        tag = "R3"; wr(0, 8'h01); rd(0); step(2);
        do_reset();
        tag = "R2"; wr(1, 8'h00); rd(0); step(2);
        tag = "R4"; wr(0, 8'h02); step(2); wr(0, 8'h01); wr(0, 8'h00); wr(0, 8'h03); rd(0);
        tag = "R5"; wr(1, 8'h01); step(3); wr(0, 8'h00); rd(1); wr(1, 8'h00); step(2);
        tag = "R6";
        for (int p = 0; p < 4; p++) begin
          pin_in = 2'(p); step(1); rd(2); step(3); rd(2);
        end
        tag = "R7"; pin_in = 2'b10; step(4);
        wr(1, 8'h02); step(4); rd(2); wr(0, 8'h00); wr(0, 8'h02);
        wr(1, 8'h03); step(2); rd(2); rd(1);
        tag = "R8"; pin_in = 2'b11; step(6); pin_in = 2'b10; step(6);
        rd(2); step(3); pin_in = 2'b11; step(2); pin_in = 2'b00; step(5); rd(2); step(3);
        tag = "R9";
        @(negedge clk); pin_in = 2'b01;
        @(negedge clk);
        @(negedge clk); rd_en = 1; rd_addr = 2;
        @(negedge clk); rd_en = 0; step(4); rd(2); step(3);
        tag = "R10"; wr(2, 8'hff); wr(3, 8'hff); rd(0); rd(1); rd(3); step(3); rd(2);
        wr(1, 8'h00); step(2); rd(3); step(4);
      end
      begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule